// File: doc/BRIEF.md
# Reloadable-Coefficient 32-Tap FIR Filter

This block is a 32-tap finite impulse response filter. It runs on the system clock and takes one sample in every four cycles. Each input sample is pushed into a 32-entry delay line. Over the next four cycles the 32 products are summed, eight taps per cycle, by one group of eight parallel multipliers that is reused in turn. The sum is then truncated and presented on the output with a one-cycle valid pulse.

Coefficients can be replaced while the block runs. A one-cycle pulse on `load` takes the filter offline and `in_ready` falls. The new coefficients then arrive on `coef_in`, one per cycle in which `coef_we` is high, starting at tap 0. After the 32nd write the filter waits a fixed settle time, raises `in_ready` and resumes. The delay line contents survive a reload.

The sample input is a valid/ready stream. A sample transfers on a cycle where `in_valid` and `in_ready` are both high. A producer that sees `in_ready` low must hold `in_valid` and `in_data` until the transfer. `in_ready` also depends combinationally on `load`, so a sample is never accepted in the cycle of a load pulse. The output has no back-pressure: `out_valid` is a one-cycle pulse that the consumer must capture. `out_data` keeps its value until the next pulse.

Top module: `reload_fir`

## Requirements
- R1: After reset all coefficients are zero, the delay line is cleared, `in_ready` is high, `out_valid` is low and `out_data` is 0. Samples filtered with the reset coefficients give an output of 0.
- R2: A sample is accepted only in a cycle with `in_valid` and `in_ready` both high. After an acceptance `in_ready` stays low for three cycles, so two acceptances are never less than four cycles apart. Back-to-back samples are accepted exactly four cycles apart.
- R3: Exactly four clock edges after the edge that accepts a sample, `out_valid` is high for one cycle. At the same time `out_data` holds y = floor(sum over k of c[k]*x[n-k] / 2048), where x[n] is the new sample at tap 0 and tap k holds the sample accepted k samples earlier. y is given as an 18-bit two's complement value.
- R4: Coefficients are 12-bit signed values with 11 fractional bits. Samples are 12-bit signed integers. During a reload the first strobed coefficient goes to tap 0 and the 32nd goes to tap 31.
- R5: A `load` pulse takes effect in any state. In the cycle of the pulse `in_ready` is low. In the following cycle `in_ready` and `out_valid` are low. A sample still being summed is dropped and produces no output.
- R6: During a reload each cycle with `coef_we` high stores one coefficient, and a cycle with `coef_we` low stores nothing. After the edge that takes the 32nd coefficient, `in_ready` goes high after exactly 3 further clock edges.
- R7: While reloading, `in_valid` is ignored, the delay line keeps its contents and `out_data` keeps its value.
- R8: `coef_we` has no effect outside a reload, and neither does a `coef_we` in the cycle of a `load` pulse.
- R9: `out_data` changes only in a cycle where `out_valid` is high.
- R10: The accumulator never overflows. With every coefficient and every sample at -2048 the output is exactly 65536. With every coefficient at -2048 and every sample at 2047 the output is exactly -65504.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | One-cycle pulse that starts a coefficient reload |
| coef_we | input | 1 | Strobe marking `coef_in` valid during a reload |
| coef_in | input | 12 | Signed coefficient, 11 fractional bits |
| in_valid | input | 1 | Sample stream valid |
| in_ready | output | 1 | Ready for a sample; low while summing or reloading |
| in_data | input | 12 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 18 | Filter result, held between pulses |

## Verification
Several stimulus patterns drive the filter, each aimed at a different failure.
- Zero coefficients after reset show that the state was cleared.
- Coefficients that differ at every tap, with gaps between the strobes, expose a wrong tap order or a miscounted write.
- A continuous stream of pseudo-random samples at full rate, compared with a sparse stream, separates a wrong cadence from a wrong sum.
- Full-scale coefficients with full-scale samples of both signs expose accumulator overflow and a wrong rounding direction.
- A reload started in the middle of a sum shows that the partial result is dropped.
- Strobes sent outside a reload, while the filter keeps streaming, must leave the output unchanged.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_LOAD   = 2'd2,
    ST_SETTLE = 2'd3
  } fir_state_e;
endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pkg::*;
#(
  parameter  int TAPS       = 32,
  parameter  int PHASES     = 4,
  parameter  int SETTLE_CYC = 3,
  localparam int PH_W       = $clog2(PHASES),
  localparam int IDX_W      = $clog2(TAPS),
  localparam int SC_W       = $clog2(SETTLE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             coef_we,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             take,
  output logic             mac_en,
  output logic             out_fire,
  output logic             coef_wr,
  output logic [IDX_W-1:0] wr_idx,
  output logic [PH_W-1:0]  phase
);
  fir_state_e       st;
  logic [PH_W-1:0]  phase_q;
  logic [IDX_W-1:0] wr_cnt;
  logic [SC_W-1:0]  settle_q;
  logic             last_phase;

  assign last_phase = (phase_q == PH_W'(PHASES - 1));
  assign in_ready   = !load && ((st == ST_IDLE) || (st == ST_RUN && last_phase));
  assign take       = in_valid && in_ready;
  assign mac_en     = (st == ST_RUN) && !load;
  assign out_fire   = mac_en && last_phase;
  assign coef_wr    = (st == ST_LOAD) && coef_we && !load;
  assign wr_idx     = wr_cnt;
  assign phase      = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      phase_q  <= '0;
      wr_cnt   <= '0;
      settle_q <= '0;
    end else if (load) begin
      st     <= ST_LOAD;
      wr_cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (take) begin
          st      <= ST_RUN;
          phase_q <= '0;
        end
        ST_RUN: if (last_phase) begin
          phase_q <= '0;
          if (!take) st <= ST_IDLE;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
        ST_LOAD: if (coef_we) begin
          if (wr_cnt == IDX_W'(TAPS - 1)) begin
            st       <= ST_SETTLE;
            settle_q <= SC_W'(SETTLE_CYC);
          end else begin
            wr_cnt <= wr_cnt + 1'b1;
          end
        end
        ST_SETTLE: if (settle_q == SC_W'(1)) st <= ST_IDLE;
                   else settle_q <= settle_q - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter  int TAPS   = 32,
  parameter  int COEF_W = 12,
  localparam int IDX_W  = $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [IDX_W-1:0]         idx,
  input  logic signed [COEF_W-1:0] din,
  output logic signed [COEF_W-1:0] coef [TAPS]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) coef[i] <= '0;
    end else if (wr) begin
      coef[idx] <= din;
    end
  end
endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int TAPS   = 32,
  parameter int SAMP_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift,
  input  logic signed [SAMP_W-1:0] din,
  output logic signed [SAMP_W-1:0] taps [TAPS]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) taps[i] <= '0;
    end else if (shift) begin
      taps[0] <= din;
      for (int i = 1; i < TAPS; i++) taps[i] <= taps[i-1];
    end
  end
endmodule

// File: rtl/fir_mac_group.sv
module fir_mac_group #(
  parameter  int GROUP  = 8,
  parameter  int COEF_W = 12,
  parameter  int SAMP_W = 12,
  localparam int PROD_W = COEF_W + SAMP_W,
  localparam int SUM_W  = PROD_W + $clog2(GROUP)
) (
  input  logic signed [COEF_W-1:0] c [GROUP],
  input  logic signed [SAMP_W-1:0] s [GROUP],
  output logic signed [SUM_W-1:0]  sum
);
  logic signed [PROD_W-1:0] prod [GROUP];

  for (genvar g = 0; g < GROUP; g++) begin : g_mul
    logic signed [PROD_W-1:0] c_ext, s_ext;
    assign c_ext   = PROD_W'(c[g]);
    assign s_ext   = PROD_W'(s[g]);
    assign prod[g] = c_ext * s_ext;
  end

  always_comb begin
    sum = '0;
    for (int g = 0; g < GROUP; g++) sum = sum + SUM_W'(prod[g]);
  end
endmodule

// File: rtl/reload_fir.sv
module reload_fir #(
  parameter  int TAPS       = 32,
  parameter  int PHASES     = 4,
  parameter  int COEF_W     = 12,
  parameter  int COEF_FRAC  = 11,
  parameter  int SAMP_W     = 12,
  parameter  int SETTLE_CYC = 3,
  localparam int GROUP      = TAPS / PHASES,
  localparam int PROD_W     = COEF_W + SAMP_W,
  localparam int SUM_W      = PROD_W + $clog2(GROUP),
  localparam int ACC_W      = PROD_W + $clog2(TAPS),
  localparam int OUT_W      = ACC_W - COEF_FRAC,
  localparam int PH_W       = $clog2(PHASES),
  localparam int IDX_W      = $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     coef_we,
  input  logic signed [COEF_W-1:0] coef_in,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [SAMP_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_data
);
  logic             take, mac_en, out_fire, coef_wr;
  logic [IDX_W-1:0] wr_idx;
  logic [PH_W-1:0]  phase;

  logic signed [COEF_W-1:0] coef_q [TAPS];
  logic signed [SAMP_W-1:0] taps_q [TAPS];
  logic signed [COEF_W-1:0] c_sel  [GROUP];
  logic signed [SAMP_W-1:0] s_sel  [GROUP];
  logic signed [SUM_W-1:0]  grp_sum;
  logic signed [ACC_W-1:0]  acc_q, total;

  fir_ctrl #(.TAPS(TAPS), .PHASES(PHASES), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load), .coef_we(coef_we),
    .in_valid(in_valid), .in_ready(in_ready), .take(take), .mac_en(mac_en),
    .out_fire(out_fire), .coef_wr(coef_wr), .wr_idx(wr_idx), .phase(phase)
  );

  fir_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W)) u_coef (
    .clk(clk), .rst_n(rst_n), .wr(coef_wr), .idx(wr_idx), .din(coef_in), .coef(coef_q)
  );

  fir_delay_line #(.TAPS(TAPS), .SAMP_W(SAMP_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .shift(take), .din(in_data), .taps(taps_q)
  );

  // Phase p reads taps p*GROUP .. p*GROUP+GROUP-1.
  always_comb begin
    for (int g = 0; g < GROUP; g++) begin
      c_sel[g] = coef_q[IDX_W'(int'(phase) * GROUP + g)];
      s_sel[g] = taps_q[IDX_W'(int'(phase) * GROUP + g)];
    end
  end

  fir_mac_group #(.GROUP(GROUP), .COEF_W(COEF_W), .SAMP_W(SAMP_W)) u_mac (
    .c(c_sel), .s(s_sel), .sum(grp_sum)
  );

  assign total = acc_q + ACC_W'(grp_sum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (mac_en) acc_q <= total;
      if (out_fire) begin
        // Drop the fractional bits: floor toward minus infinity.
        out_data  <= total[ACC_W-1:COEF_FRAC];
        out_valid <= 1'b1;
      end
      if (take) acc_q <= '0;
    end
  end
endmodule

// File: rtl/fir_checker.sv
module fir_checker #(
  parameter int OUT_W = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    load,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data
);
  logic [1:0] gap_q;
  logic       acc_ok;

  assign acc_ok = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)           gap_q <= 2'd3;
    else if (acc_ok)      gap_q <= 2'd0;
    else if (gap_q != 2'd3) gap_q <= gap_q + 2'd1;
  end

  assert_in_cadence_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |-> (gap_q == 2'd3));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> !in_ready);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_load_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !in_ready);

  assert_load_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !out_valid);

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

bind reload_fir fir_checker #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_reload_fir.sv
module sim_reload_fir;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0, coef_we = 1'b0, in_valid = 1'b0;
  logic signed [11:0] coef_in = '0, in_data = '0;
  logic in_ready, out_valid;
  logic signed [17:0] out_data;

  always #5 clk = ~clk;

  reload_fir u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .coef_we(coef_we), .coef_in(coef_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  int unsigned seed = 32'h1234_5678;

  // Behavioural reference: mode 0 idle, 1 summing, 2 reloading, 3 settling.
  int m_mode, m_phase, m_cnt, m_settle;
  int m_coef [32];
  int m_dl [32];
  longint m_sum;
  logic signed [17:0] m_out;
  bit m_vld, m_took;

  task automatic m_accept(int x);
    for (int i = 31; i > 0; i--) m_dl[i] = m_dl[i-1];
    m_dl[0] = x;
    m_sum = 0;
    for (int i = 0; i < 32; i++) m_sum += longint'(m_coef[i]) * longint'(m_dl[i]);
    m_took = 1'b1;
  endtask

  always @(posedge clk) begin
    m_vld = 1'b0;
    m_took = 1'b0;
    if (!rst_n) begin
      m_mode = 0; m_phase = 0; m_cnt = 0; m_settle = 0; m_sum = 0; m_out = '0;
      for (int i = 0; i < 32; i++) begin m_coef[i] = 0; m_dl[i] = 0; end
    end else if (load) begin
      m_mode = 2; m_cnt = 0;
    end else begin
      case (m_mode)
        0: if (in_valid) begin m_accept(int'(in_data)); m_mode = 1; m_phase = 0; end
        1: if (m_phase == 3) begin
             m_out = 18'(m_sum >>> 11);
             m_vld = 1'b1;
             if (in_valid) begin m_accept(int'(in_data)); m_phase = 0; end
             else m_mode = 0;
           end else m_phase++;
        2: if (coef_we) begin
             m_coef[m_cnt] = int'(coef_in);
             if (m_cnt == 31) begin m_mode = 3; m_settle = 3; end
             else m_cnt++;
           end
        default: if (m_settle == 1) m_mode = 0; else m_settle--;
      endcase
    end
  end

  task automatic chk(string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit exp_rdy;
    @(negedge clk);
    exp_rdy = ((m_mode == 0) || (m_mode == 1 && m_phase == 3)) && !load;
    chk("in_ready", longint'(in_ready), longint'(exp_rdy));
    chk("out_valid", longint'(out_valid), longint'(m_vld));
    chk("out_data", longint'(out_data), longint'(m_out));
  endtask

  function automatic logic signed [11:0] rnd12();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[27:16];
  endfunction

  function automatic logic signed [11:0] coef_of(int kind, int k);
    case (kind)
      0: return 12'(((k * 411 + 97) % 4096) - 2048);
      1: return -12'sd2048;
      default: return (k % 2 == 1) ? 12'(-k * 60) : 12'(k * 50 + 3);
    endcase
  endfunction

  // Reload with strobe gaps; samples offered throughout (R7).
  task automatic reload(int kind);
    load = 1'b1; coef_we = 1'b1; coef_in = 12'sd777; tick();
    load = 1'b0; coef_we = 1'b0;
    for (int k = 0; k < 32; k++) begin
      in_valid = 1'b1; in_data = rnd12();
      if (k % 5 == 2) begin coef_we = 1'b0; coef_in = rnd12(); tick(); end
      coef_we = 1'b1; coef_in = coef_of(kind, k); tick();
    end
    coef_we = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < 5; i++) tick();
  endtask

  // mode 0 random, 1 fixed value; gap idle cycles after each accept.
  task automatic stream(int n, int gap, int mode, int fixed, bit strobe);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = (mode == 1) ? 12'(fixed) : rnd12();
      coef_we  = strobe; coef_in = rnd12();
      tick();
      while (!m_took) tick();
      in_valid = 1'b0;
      for (int j = 0; j < gap; j++) tick();
    end
    coef_we = 1'b0;
    for (int i = 0; i < 6; i++) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    tick();
    rst_n = 1'b1;
    tick();
    stream(5, 0, 0, 0, 1'b0);           // R1: zero coefficients give zero
    cur_req = "R6 R7 R4";
    reload(0);
    cur_req = "R2 R3 R4";
    stream(40, 0, 0, 0, 1'b0);           // full rate
    cur_req = "R2 R9";
    stream(10, 6, 0, 0, 1'b0);           // sparse
    cur_req = "R8";
    stream(12, 1, 0, 0, 1'b1);           // strobes outside reload
    cur_req = "R5";
    in_valid = 1'b1; in_data = rnd12(); tick();
    in_valid = 1'b0; tick(); tick();
    reload(2);                           // load in the middle of a sum
    stream(36, 0, 0, 0, 1'b0);
    cur_req = "R10";
    reload(1);
    stream(34, 0, 1, -2048, 1'b0);       // expect 65536
    stream(34, 2, 1, 2047, 1'b0);        // expect -65504
    finish_run();
  end
endmodule